// File: doc/BRIEF.md
# IF Frequency Discriminator

This block decides whether an intermediate-frequency signal sits on its expected frequency. It counts the rising edges of the IF input over a gate window derived from the crystal clock, and at the end of each gate it reports whether the edge count fell within a programmable tolerance of a programmed target. Measurements repeat back to back for as long as a measuring mode is selected, so a tuning controller can poll the strobe to decide whether a station is present.

The gate comes from a 14-bit prescaler and a power-of-two tick divider. A down-counter is preloaded with the expected edge count, which is the mode's nominal edges per tick, scaled by the gate length and shifted by a signed center adjust. Each rising IF edge decrements it. When the gate closes, the residual is read as a signed number of the counter's active width, and its magnitude is compared with the window. A residual of zero means the count was exact. A residual of all ones means the counter wrapped by one edge.

A four-state machine sequences the work. `ST_IDLE` waits while the mode is off. `LOAD` moves from `ST_LOAD` to `ST_COUNT` after presetting the counter and clearing the timer. `COUNT` runs from `ST_COUNT` to `ST_CHECK` when the gate closes. `RELOAD` goes from `ST_CHECK` to `ST_LOAD` after the verdict is registered. `OFF` leaves any state for `ST_IDLE` as soon as the mode field reads off. `START` goes from `ST_IDLE` to `ST_LOAD` when a mode is selected.

Top module: `if_freq_meter`

## Requirements
- R1: With `mode_sel` = 2'b00 (off), the machine returns to idle on the next clock and no `meas_valid` strobe is produced, abandoning any measurement under way. The other codes are 2'b01 FM, 2'b10 AM and 2'b11 AM up-conversion.
- R2: A measurement takes G+2 clocks, where G = `base_div` × 2^`gate_sel`, and a `base_div` of 0 counts as 16384. Consecutive strobes within one configuration are therefore G+2 clocks apart.
- R3: The expected count is NOMINAL(mode) × 2^`gate_sel` + `ctr_adj`, with `ctr_adj` read as 5-bit two's complement. The verdict is in-window when |edges − expected| ≤ 2^`win_sel`.
- R4: Only rising edges of `if_in` are counted, after a two-flop synchroniser. The duty cycle of the input does not change the result.
- R5: The counter is 11 bits wide in AM mode with `gate_sel` ≤ 1, and 21 bits wide otherwise. The residual wraps at the active width, so an AM short-gate deviation of exactly 2048 edges reads as in-window, while the same input in a 21-bit mode reads as out.
- R6: `meas_valid` is a single-cycle pulse, and `meas_in_win` is high only in a cycle where `meas_valid` is high.
- R7: After reset, `meas_valid` and `meas_in_win` are low.
- R8: A deviation of exactly ± the window width is accepted, and a deviation of one edge more is rejected.
- R9: After each verdict the counter reloads and a new measurement starts without any further stimulus. An exact count is accepted on every repetition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_in | input | 1 | IF input, asynchronous to clk |
| mode_sel | input | 2 | 00 off, 01 FM, 10 AM, 11 AM up-conversion |
| base_div | input | 14 | Prescaler ratio, in clocks per tick (0 = 16384) |
| gate_sel | input | 3 | Gate length exponent, giving 2^gate_sel ticks |
| ctr_adj | input | 5 | Signed offset added to the expected count |
| win_sel | input | 3 | Window exponent, giving ±2^win_sel edges |
| meas_valid | output | 1 | One-cycle strobe at the end of each measurement |
| meas_in_win | output | 1 | Verdict that comes with the strobe |

## Verification
A corrupted residual shows up as a wrong `meas_in_win` on the very next strobe, one G+2 period after the fault at the latest. A timer or state fault shifts the strobe spacing away from G+2 clocks, or produces strobes while the mode is off, within one measurement. The scoreboard therefore checks the verdict and the spacing of every strobe, using counts chosen to sit exactly on, just inside and just outside the window edges, and on the 11-bit wrap.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_FM  = 2'b01,
        MODE_AM  = 2'b10,
        MODE_UPC = 2'b11
    } ifc_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_COUNT = 2'd2,
        ST_CHECK = 2'd3
    } ifc_state_e;

endpackage

// File: rtl/ifc_edge_sync.sv
module ifc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ifc_gate_timer.sv
module ifc_gate_timer #(
    parameter int DIV_W = 14,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] base_div,
    input  logic [SEL_W-1:0] gate_sel,
    output logic             gate_done
);
    localparam int TICK_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0]  pre_q;
    logic [TICK_W-1:0] tick_q;
    logic [DIV_W-1:0]  pre_last;
    logic [TICK_W-1:0] tick_last;
    logic              tick;

    assign pre_last  = base_div - DIV_W'(1);
    assign tick_last = TICK_W'((32'd1 << gate_sel) - 32'd1);
    assign tick      = run && (pre_q == pre_last);
    assign gate_done = tick && (tick_q == tick_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            tick_q <= '0;
        end else if (restart) begin
            pre_q  <= '0;
            tick_q <= '0;
        end else if (run) begin
            if (tick) begin
                pre_q  <= '0;
                tick_q <= tick_q + TICK_W'(1);
            end else begin
                pre_q  <= pre_q + DIV_W'(1);
            end
        end
    end
endmodule

// File: rtl/ifc_main_counter.sv
module ifc_main_counter #(
    parameter int CNT_W   = 21,
    parameter int SHORT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] preload,
    input  logic             dec,
    input  logic             short_len,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] SHORT_MASK = CNT_W'((64'd1 << SHORT_W) - 64'd1);

    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] count_q;

    assign mask = short_len ? SHORT_MASK : '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count_q <= '0;
        else if (load)  count_q <= preload & mask;
        else if (dec)   count_q <= (count_q - CNT_W'(1)) & mask;
    end

    assign count_o = count_q;
endmodule

// File: rtl/ifc_window_check.sv
module ifc_window_check #(
    parameter int CNT_W   = 21,
    parameter int SHORT_W = 11,
    parameter int WSEL_W  = 3
) (
    input  logic [CNT_W-1:0]  count,
    input  logic              short_len,
    input  logic [WSEL_W-1:0] win_sel,
    output logic              in_win
);
    localparam int RW = CNT_W + 1;

    logic [RW-1:0] resid;
    logic [RW-1:0] span;

    always_comb begin
        if (short_len)
            resid = {{(RW-SHORT_W){count[SHORT_W-1]}}, count[SHORT_W-1:0]};
        else
            resid = {count[CNT_W-1], count};
        span   = RW'(1) << win_sel;
        in_win = ($signed(resid) <= $signed(span)) &&
                 ($signed(resid) >= -$signed(span));
    end
endmodule

// File: rtl/if_freq_meter.sv
module if_freq_meter
    import ifc_pkg::*;
#(
    parameter int DIV_W         = 14,
    parameter int SEL_W         = 3,
    parameter int ADJ_W         = 5,
    parameter int WSEL_W        = 3,
    parameter int CNT_W         = 21,
    parameter int SHORT_W       = 11,
    parameter int SHORT_SEL_MAX = 1,
    parameter int NOM_FM        = 1712,
    parameter int NOM_AM        = 450,
    parameter int NOM_UPC       = 10700,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_in,
    input  logic [1:0]        mode_sel,
    input  logic [DIV_W-1:0]  base_div,
    input  logic [SEL_W-1:0]  gate_sel,
    input  logic [ADJ_W-1:0]  ctr_adj,
    input  logic [WSEL_W-1:0] win_sel,
    output logic              meas_valid,
    output logic              meas_in_win
);
    ifc_state_e        state_q, state_d;
    ifc_mode_e         mode;
    logic              if_rise;
    logic              gate_done;
    logic              counting;
    logic              loading;
    logic              short_now;
    logic              short_q;
    logic [WSEL_W-1:0] win_q;
    logic [CNT_W-1:0]  nominal;
    logic [CNT_W-1:0]  preload;
    logic [CNT_W-1:0]  count_q;
    logic              verdict;

    assign mode     = ifc_mode_e'(mode_sel);
    assign counting = (state_q == ST_COUNT);
    assign loading  = (state_q == ST_LOAD);

    always_comb begin
        unique case (mode)
            MODE_FM:  nominal = CNT_W'(NOM_FM);
            MODE_AM:  nominal = CNT_W'(NOM_AM);
            MODE_UPC: nominal = CNT_W'(NOM_UPC);
            default:  nominal = '0;
        endcase
        preload   = (nominal << gate_sel) +
                    {{(CNT_W-ADJ_W){ctr_adj[ADJ_W-1]}}, ctr_adj};
        short_now = (mode == MODE_AM) && (int'(gate_sel) <= SHORT_SEL_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            short_q <= 1'b0;
            win_q   <= '0;
        end else if (loading) begin
            short_q <= short_now;
            win_q   <= win_sel;
        end
    end

    ifc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (if_in),
        .rise_o   (if_rise)
    );

    ifc_gate_timer #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (loading),
        .run       (counting),
        .base_div  (base_div),
        .gate_sel  (gate_sel),
        .gate_done (gate_done)
    );

    ifc_main_counter #(.CNT_W(CNT_W), .SHORT_W(SHORT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (loading),
        .preload   (preload),
        .dec       (counting && if_rise),
        .short_len (loading ? short_now : short_q),
        .count_o   (count_q)
    );

    ifc_window_check #(.CNT_W(CNT_W), .SHORT_W(SHORT_W), .WSEL_W(WSEL_W)) u_judge (
        .count     (count_q),
        .short_len (short_q),
        .win_sel   (win_q),
        .in_win    (verdict)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_COUNT;
            ST_COUNT: if (gate_done) state_d = ST_CHECK;
            ST_CHECK: state_d = ST_LOAD;
            default:  state_d = ST_IDLE;
        endcase
        if (mode == MODE_OFF) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meas_valid  <= 1'b0;
            meas_in_win <= 1'b0;
        end else begin
            meas_valid  <= (state_q == ST_CHECK);
            meas_in_win <= (state_q == ST_CHECK) && verdict;
        end
    end
endmodule

// File: rtl/if_freq_meter_chk.sv
module if_freq_meter_chk #(
    parameter int CNT_W   = 21,
    parameter int SHORT_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_sel,
    input logic             meas_valid,
    input logic             meas_in_win,
    input logic             counting,
    input logic             if_rise,
    input logic [CNT_W-1:0] count,
    input logic             short_len
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             age_q <= 2'd0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    a_r1_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(mode_sel) == 2'b00 && $past(mode_sel, 2) == 2'b00)
        |-> !meas_valid);

    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |=> !meas_valid);

    a_r6_flag_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid |-> !meas_in_win);

    a_r4_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && !if_rise) |=> $stable(count));

    a_r5_short_width: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && short_len) |-> (count[CNT_W-1:SHORT_W] == '0));
endmodule

bind if_freq_meter if_freq_meter_chk #(.CNT_W(CNT_W), .SHORT_W(SHORT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .meas_valid  (meas_valid),
    .meas_in_win (meas_in_win),
    .counting    (counting),
    .if_rise     (if_rise),
    .count       (count_q),
    .short_len   (short_q)
);

// File: tb/if_freq_meter_bench.sv
module if_freq_meter_bench;

    localparam int NFM = 6;
    localparam int NAM = 3;
    localparam int NUP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       if_in = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [13:0] base_div = 14'd24;
    logic [2:0] gate_sel = 3'd0;
    logic [4:0] ctr_adj = 5'd0;
    logic [2:0] win_sel = 3'd0;
    logic       meas_valid;
    logic       meas_in_win;

    if_freq_meter #(.NOM_FM(NFM), .NOM_AM(NAM), .NOM_UPC(NUP)) u_if_freq_meter (
        .clk(clk), .rst_n(rst_n), .if_in(if_in), .mode_sel(mode_sel),
        .base_div(base_div), .gate_sel(gate_sel), .ctr_adj(ctr_adj),
        .win_sel(win_sel), .meas_valid(meas_valid), .meas_in_win(meas_in_win)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit    exp_win;
        bit    chk_gap;
        int    gap;
        string tag;
    } item_t;

    item_t q[$];
    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int last_valid = 0;
    int stray = 0;
    int if_per = 4;
    int if_hi = 2;
    int ph = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (ph >= if_per - 1) ph = 0;
        else ph = ph + 1;
        if_in = (ph < if_hi);
    end

    task automatic report(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && meas_valid) begin
            if (q.size() == 0) begin
                stray++;
                report(1'b0, "R1 strobe with nothing expected", 1, 0);
            end else begin
                item_t it;
                it = q.pop_front();
                report(meas_in_win == it.exp_win, it.tag, int'(meas_in_win), int'(it.exp_win));
                if (it.chk_gap)
                    report((cyc - last_valid) == it.gap, {"R2 gap ", it.tag},
                           cyc - last_valid, it.gap);
            end
            last_valid = cyc;
        end
    end

    task automatic measure(input logic [1:0] m, input int sel, input int cf, input int ew,
                           input int base, input int per, input int hi, input int n,
                           input string tag);
        longint nom, pre, edges, r, w, span, beff;
        bit exp;
        int lim;
        @(negedge clk);
        mode_sel = 2'b00;
        repeat (3) @(negedge clk);
        if_per = per; if_hi = hi; ph = 0;
        base_div = 14'(base); gate_sel = 3'(sel); ctr_adj = 5'(cf); win_sel = 3'(ew);
        beff  = (base == 0) ? 16384 : base;
        nom   = (m == 2'b01) ? NFM : (m == 2'b10) ? NAM : NUP;
        pre   = (nom << sel) + cf;
        edges = (beff / per) << sel;
        w     = (m == 2'b10 && sel <= 1) ? 11 : 21;
        r     = (pre - edges) & ((64'd1 << w) - 1);
        if (r >= (64'd1 << (w - 1))) r = r - (64'd1 << w);
        span  = 64'd1 << ew;
        exp   = (r <= span) && (r >= -span);
        for (int i = 0; i < n; i++) begin
            item_t it;
            it.exp_win = exp; it.chk_gap = (i != 0);
            it.gap = int'((beff << sel) + 2); it.tag = tag;
            q.push_back(it);
        end
        @(negedge clk);
        mode_sel = m;
        lim = 0;
        while (q.size() > 0 && lim < 60000) begin
            @(negedge clk);
            lim++;
        end
        mode_sel = 2'b00;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        report(meas_valid == 1'b0, "R7 valid in reset", int'(meas_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        report(meas_valid == 1'b0 && meas_in_win == 1'b0, "R7 outputs after reset",
               int'({meas_valid, meas_in_win}), 0);

        // R1: off mode stays silent
        base_div = 14'd4; mode_sel = 2'b00;
        repeat (300) @(negedge clk);
        report(stray == 0, "R1 off mode strobes", stray, 0);

        // R9 / R3: exact count, repeated
        measure(2'b01, 2, 0, 0, 24, 4, 2, 3, "R9 FM exact repeats");
        measure(2'b11, 3, 0, 0, 24, 3, 1, 2, "R3 UPC exact");
        // R8 window boundaries
        measure(2'b01, 2, 1, 0, 24, 4, 2, 2, "R8 dev -1 win 1 in");
        measure(2'b01, 2, 2, 0, 24, 4, 2, 2, "R8 dev -2 win 1 out");
        measure(2'b01, 2, 2, 1, 24, 4, 2, 2, "R8 dev -2 win 2 in");
        measure(2'b01, 2, -3, 1, 24, 4, 2, 2, "R8 dev +3 win 2 out");
        measure(2'b01, 2, -3, 2, 24, 4, 2, 2, "R8 dev +3 win 4 in");
        measure(2'b11, 3, 0, 3, 24, 4, 2, 2, "R3 UPC dev -16 win 8 out");
        measure(2'b11, 3, 0, 4, 24, 4, 2, 2, "R3 UPC dev -16 win 16 in");
        // R4: duty cycle does not matter
        measure(2'b10, 0, 0, 0, 24, 8, 1, 2, "R4 AM narrow high");
        measure(2'b10, 0, -1, 0, 24, 8, 7, 2, "R4 AM wide high dev +1");
        measure(2'b10, 2, 0, 0, 24, 8, 4, 2, "R4 AM long gate");
        // R5: short counter wraps at 2048
        measure(2'b10, 0, 0, 0, 4102, 2, 1, 2, "R5 AM short alias 2048 in");
        measure(2'b01, 0, -3, 0, 4102, 2, 1, 2, "R5 FM long dev 2048 out");
        // R2: base_div of zero
        measure(2'b11, 0, 0, 7, 0, 2, 1, 2, "R2 base zero out");

        mode_sel = 2'b00;
        repeat (20) @(negedge clk);
        report(q.size() == 0, "R9 results outstanding", q.size(), 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule